// File: doc/BRIEF.md
# Shared Serial EEPROM Bus Arbiter

This block decides who may drive a three-wire serial EEPROM bus (select, clock, data) that a local configuration engine shares with outside board logic. The two sides coordinate through a pair of busy lines. The local side raises its own busy output to claim or request the bus. It samples the outside party's busy line through a synchronizer.

After reset the block owns the bus at once, without asking. It runs one read of the configuration area and then releases the bus. It releases by turning off the pad enables, which leaves the pins pulled low, and by dropping its busy output. A later wake command makes the block request the bus again. It takes the bus only once the outside party's busy line has been seen low. It then starts a read at the address where the card resource data begins.

The serial command protocol is out of scope. It sits behind a start/done/address interface, with a pending flag that marks a requested read not yet launched.

Top module: `seeprom_share_arb`

## Requirements
- R1: While reset is asserted, and until the first start pulse, `loc_busy_o` and `pin_oe_o` are 1. One clock edge after reset is released, `eng_start_o` is 1 for one cycle with `eng_addr_o` equal to CFG_ADDR (default 0).
- R2: A done pulse accepted while the block owns the bus and no start is pending causes `pin_oe_o` and `loc_busy_o` to be 0 after the next clock edge (the wait-for-key state).
- R3: A wake pulse in the wait-for-key state sets `loc_busy_o` and `eng_pend_o` to 1 and `eng_addr_o` to WAKE_ADDR (default 0x0E) after the next edge. Address and pending flag hold until the start pulse.
- R4: The block takes the bus only after it has seen `ext_busy_i` low through a 2-flop synchronizer while requesting. With `ext_busy_i` held low, `pin_oe_o` rises one edge after `loc_busy_o` rises, and the start pulse appears in that same cycle.
- R5: `eng_start_o` is a single-cycle pulse. It occurs only while `pin_oe_o` is 1, and at most once per ownership period.
- R6: With an outside party that drives the bus no earlier than two edges after raising `ext_busy_i`, only while `loc_busy_o` is low, and that withdraws its request when it sees `loc_busy_o` high before it drives, the two parties never drive in the same cycle.
- R7: While `pin_oe_o` is 0, the select, clock and data outputs are 0. While it is 1, they follow the engine's inputs.
- R8: A wake pulse outside the wait-for-key state is ignored. It causes no further request or start.
- R9: A done pulse outside ownership (waiting or requesting) is ignored. Outputs are unchanged.
- R10: While `ext_busy_i` stays high, a request waits without limit. When `ext_busy_i` falls before an edge E, `pin_oe_o` is 1 after edge E+2 and 0 after edges E and E+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake_i | input | 1 | Wake command pulse; leaves the wait-for-key state |
| ext_busy_i | input | 1 | Outside party busy/request line (asynchronous) |
| loc_busy_o | output | 1 | Local busy/request line |
| pin_oe_o | output | 1 | Pad enable for select, clock and data pins |
| pin_cs_o | output | 1 | Chip-select pin value |
| pin_sck_o | output | 1 | Serial clock pin value |
| pin_sio_o | output | 1 | Serial data pin value |
| eng_cs_i | input | 1 | Select from the protocol engine |
| eng_sck_i | input | 1 | Serial clock from the protocol engine |
| eng_sio_i | input | 1 | Serial data from the protocol engine |
| eng_start_o | output | 1 | Start pulse to the protocol engine |
| eng_pend_o | output | 1 | A read is requested but not yet started |
| eng_addr_o | output | ADDR_W | Read start address |
| eng_done_i | input | 1 | Transaction complete pulse from the engine |

## Verification
The assertions check on every cycle the rules that local signals fully decide. Owning implies busy. Pins are quiet without ownership. A start happens only while owning and lasts one cycle. The pending address stays fixed, a request enters on a wake, and the bus is released after an accepted done. Any rise of ownership must be preceded, three edges earlier, by a low outside busy line. The bench scenarios are needed for what depends on the other party's conduct. These are the absence of overlap when a randomly timed outside party obeys the two-cycle rule, the exact grant latency after the outside line falls, the address sequence across reset and wakes, and wakes and done pulses that arrive at the wrong moment and must leave no trace.

// File: rtl/seeprom_arb_pkg.sv
package seeprom_arb_pkg;

    typedef enum logic [1:0] {
        ST_BOOT = 2'd0,
        ST_OWN  = 2'd1,
        ST_WAIT = 2'd2,
        ST_REQ  = 2'd3
    } sab_state_e;

    localparam int unsigned PIN_CNT = 3;
    localparam int unsigned PIN_CS  = 0;
    localparam int unsigned PIN_SCK = 1;
    localparam int unsigned PIN_SIO = 2;

endpackage

// File: rtl/sab_sync.sv
module sab_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                assign chain_d[i] = async_i;
            end else begin : g_next
                assign chain_d[i] = chain_q[i-1];
            end
        end
    endgenerate

    // Reset high: treat the other side as busy until really sampled.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/sab_ctrl.sv
module sab_ctrl
    import seeprom_arb_pkg::*;
#(
    parameter int unsigned          ADDR_W    = 9,
    parameter logic [ADDR_W-1:0]    CFG_ADDR  = '0,
    parameter logic [ADDR_W-1:0]    WAKE_ADDR = 'h0E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_req_s_i,
    input  logic              wake_i,
    input  logic              done_i,
    output logic              busy_o,
    output logic              own_o,
    output logic              start_o,
    output logic              pend_o,
    output logic [ADDR_W-1:0] addr_o
);

    typedef struct packed {
        sab_state_e        state;
        logic              busy;
        logic              pend;
        logic [ADDR_W-1:0] addr;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.state)
            ST_BOOT: begin
                ctl_d.state = ST_OWN;
            end
            ST_OWN: begin
                if (ctl_q.pend) begin
                    ctl_d.pend = 1'b0;
                end else if (done_i) begin
                    ctl_d.state = ST_WAIT;
                    ctl_d.busy  = 1'b0;
                end
            end
            ST_WAIT: begin
                if (wake_i) begin
                    ctl_d.state = ST_REQ;
                    ctl_d.busy  = 1'b1;
                    ctl_d.pend  = 1'b1;
                    ctl_d.addr  = WAKE_ADDR;
                end
            end
            ST_REQ: begin
                if (!ext_req_s_i) ctl_d.state = ST_OWN;
            end
            default: ctl_d = ctl_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.state <= ST_BOOT;
            ctl_q.busy  <= 1'b1;
            ctl_q.pend  <= 1'b1;
            ctl_q.addr  <= CFG_ADDR;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy_o  = ctl_q.busy;
    assign own_o   = (ctl_q.state == ST_OWN) || (ctl_q.state == ST_BOOT);
    assign start_o = (ctl_q.state == ST_OWN) && ctl_q.pend;
    assign pend_o  = ctl_q.pend;
    assign addr_o  = ctl_q.addr;

endmodule

// File: rtl/sab_pinmux.sv
module sab_pinmux #(
    parameter int unsigned N_PINS = 3
) (
    input  logic              own_i,
    input  logic [N_PINS-1:0] eng_i,
    output logic [N_PINS-1:0] pin_o,
    output logic              oe_o
);

    generate
        for (genvar i = 0; i < N_PINS; i++) begin : g_pin
            // Without ownership the pad is off; the pull-down value is 0.
            assign pin_o[i] = own_i & eng_i[i];
        end
    endgenerate

    assign oe_o = own_i;

endmodule

// File: rtl/seeprom_share_arb.sv
module seeprom_share_arb
    import seeprom_arb_pkg::*;
#(
    parameter int unsigned          ADDR_W      = 9,
    parameter logic [ADDR_W-1:0]    CFG_ADDR    = '0,
    parameter logic [ADDR_W-1:0]    WAKE_ADDR   = 'h0E,
    parameter int unsigned          SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wake_i,
    input  logic              ext_busy_i,
    output logic              loc_busy_o,
    output logic              pin_oe_o,
    output logic              pin_cs_o,
    output logic              pin_sck_o,
    output logic              pin_sio_o,
    input  logic              eng_cs_i,
    input  logic              eng_sck_i,
    input  logic              eng_sio_i,
    output logic              eng_start_o,
    output logic              eng_pend_o,
    output logic [ADDR_W-1:0] eng_addr_o,
    input  logic              eng_done_i
);

    logic               ext_req_s;
    logic               own;
    logic [PIN_CNT-1:0] eng_pins;
    logic [PIN_CNT-1:0] pad_pins;

    sab_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ext_busy_i),
        .sync_o  (ext_req_s)
    );

    sab_ctrl #(
        .ADDR_W    (ADDR_W),
        .CFG_ADDR  (CFG_ADDR),
        .WAKE_ADDR (WAKE_ADDR)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .ext_req_s_i (ext_req_s),
        .wake_i      (wake_i),
        .done_i      (eng_done_i),
        .busy_o      (loc_busy_o),
        .own_o       (own),
        .start_o     (eng_start_o),
        .pend_o      (eng_pend_o),
        .addr_o      (eng_addr_o)
    );

    assign eng_pins[PIN_CS]  = eng_cs_i;
    assign eng_pins[PIN_SCK] = eng_sck_i;
    assign eng_pins[PIN_SIO] = eng_sio_i;

    sab_pinmux #(.N_PINS(PIN_CNT)) u_pinmux (
        .own_i (own),
        .eng_i (eng_pins),
        .pin_o (pad_pins),
        .oe_o  (pin_oe_o)
    );

    assign pin_cs_o  = pad_pins[PIN_CS];
    assign pin_sck_o = pad_pins[PIN_SCK];
    assign pin_sio_o = pad_pins[PIN_SIO];

endmodule

// File: rtl/sab_checker.sv
module sab_checker #(
    parameter int unsigned       ADDR_W    = 9,
    parameter logic [ADDR_W-1:0] WAKE_ADDR = 'h0E
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wake_i,
    input logic              ext_busy_i,
    input logic              loc_busy_o,
    input logic              pin_oe_o,
    input logic              pin_cs_o,
    input logic              pin_sck_o,
    input logic              pin_sio_o,
    input logic              eng_start_o,
    input logic              eng_pend_o,
    input logic [ADDR_W-1:0] eng_addr_o,
    input logic              eng_done_i
);

    p_busy_when_own_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pin_oe_o |-> loc_busy_o);

    p_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe_o && eng_done_i && !eng_pend_o) |=> (!pin_oe_o && !loc_busy_o));

    p_wake_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!loc_busy_o && wake_i) |=> (loc_busy_o && eng_pend_o && eng_addr_o == WAKE_ADDR));

    p_pend_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_pend_o && !eng_start_o) |=> (eng_pend_o && $stable(eng_addr_o)));

    p_grant_after_ext_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pin_oe_o) |-> (!$past(ext_busy_i, 3) && $past(loc_busy_o)));

    p_start_owned_r5: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start_o |-> pin_oe_o);

    p_start_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start_o |=> !eng_start_o);

    p_pins_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_oe_o |-> (!pin_cs_o && !pin_sck_o && !pin_sio_o));

endmodule

bind seeprom_share_arb sab_checker #(
    .ADDR_W    (ADDR_W),
    .WAKE_ADDR (WAKE_ADDR)
) u_sab_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .wake_i      (wake_i),
    .ext_busy_i  (ext_busy_i),
    .loc_busy_o  (loc_busy_o),
    .pin_oe_o    (pin_oe_o),
    .pin_cs_o    (pin_cs_o),
    .pin_sck_o   (pin_sck_o),
    .pin_sio_o   (pin_sio_o),
    .eng_start_o (eng_start_o),
    .eng_pend_o  (eng_pend_o),
    .eng_addr_o  (eng_addr_o),
    .eng_done_i  (eng_done_i)
);

// File: tb/test_seeprom_share_arb.sv
`timescale 1ns/1ps
module test_seeprom_share_arb;

    localparam int unsigned ADDR_W = 9;
    localparam logic [ADDR_W-1:0] CFG_A  = '0;
    localparam logic [ADDR_W-1:0] WAKE_A = 9'h00E;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wake_i = 1'b0;
    logic ext_busy_i = 1'b0;
    logic loc_busy_o, pin_oe_o, pin_cs_o, pin_sck_o, pin_sio_o;
    logic eng_cs_i = 1'b0, eng_sck_i = 1'b0, eng_sio_i = 1'b0;
    logic eng_start_o, eng_pend_o, eng_done_i = 1'b0;
    logic [ADDR_W-1:0] eng_addr_o;

    always #2.5 clk = ~clk;

    seeprom_share_arb i_seeprom_share_arb (
        .clk(clk), .rst_n(rst_n), .wake_i(wake_i), .ext_busy_i(ext_busy_i),
        .loc_busy_o(loc_busy_o), .pin_oe_o(pin_oe_o), .pin_cs_o(pin_cs_o),
        .pin_sck_o(pin_sck_o), .pin_sio_o(pin_sio_o), .eng_cs_i(eng_cs_i),
        .eng_sck_i(eng_sck_i), .eng_sio_i(eng_sio_i), .eng_start_o(eng_start_o),
        .eng_pend_o(eng_pend_o), .eng_addr_o(eng_addr_o), .eng_done_i(eng_done_i)
    );

    int unsigned n_chk = 0;
    int unsigned n_fail = 0;
    bit finished = 1'b0;

    // Models
    bit ext_auto = 1'b0;
    int ext_st = 0;
    int ext_cnt = 0;
    bit ext_drive = 1'b0;
    bit eng_active = 1'b0;
    int eng_cnt = 0;
    bit eng_done_issued = 1'b0;
    bit got_start = 1'b0;
    logic [ADDR_W-1:0] exp_addr = CFG_A;
    int unsigned seed_dummy;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit pins_expected_ok();
        if (!pin_oe_o) return (pin_cs_o == 0 && pin_sck_o == 0 && pin_sio_o == 0);
        return (pin_cs_o == eng_cs_i && pin_sck_o == eng_sck_i && pin_sio_o == eng_sio_i);
    endfunction

    task automatic ext_step();
        if (!ext_auto) return;
        case (ext_st)
            0: if ($urandom % 8 == 0) begin ext_busy_i = 1'b1; ext_st = 1; ext_cnt = 0; end
            1: begin
                if (loc_busy_o) begin
                    ext_busy_i = 1'b0; ext_st = 0;
                end else begin
                    ext_cnt++;
                    if (ext_cnt == 2) begin
                        ext_drive = 1'b1; ext_st = 2; ext_cnt = 2 + $urandom % 7;
                    end
                end
            end
            default: begin
                ext_cnt--;
                if (ext_cnt == 0) begin
                    ext_drive = 1'b0; ext_busy_i = 1'b0; ext_st = 0;
                end
            end
        endcase
    endtask

    task automatic eng_step();
        if (eng_done_i) begin
            if (eng_done_issued)
                chk(!pin_oe_o && !loc_busy_o, "R2 release after done", {pin_oe_o, loc_busy_o}, 0);
            eng_done_i = 1'b0;
            eng_done_issued = 1'b0;
        end
        if (!pin_oe_o) got_start = 1'b0;
        if (eng_start_o) begin
            chk(eng_addr_o == exp_addr, (exp_addr == CFG_A) ? "R1 start address" : "R3 start address",
                eng_addr_o, exp_addr);
            chk(!got_start, "R5 one start per ownership", got_start, 0);
            got_start = 1'b1;
            exp_addr = WAKE_A;
            eng_active = 1'b1;
            eng_cnt = 1 + $urandom % 5;
        end else if (eng_active) begin
            eng_cnt--;
            if (eng_cnt == 0) begin
                eng_active = 1'b0;
                eng_done_i = 1'b1;
                eng_done_issued = 1'b1;
            end
        end
        eng_cs_i  = eng_active;
        eng_sck_i = eng_active ? ~eng_sck_i : 1'b0;
        eng_sio_i = eng_active ? 1'($urandom % 2) : 1'b0;
    endtask

    // One cycle: wait for the falling edge, check, then update inputs.
    task automatic tick();
        @(negedge clk);
        if (rst_n) begin
            chk(!(ext_drive && pin_oe_o), "R6 no overlap", ext_drive, 0);
            chk(pins_expected_ok(), "R7 pin values", {pin_oe_o, pin_cs_o, pin_sck_o, pin_sio_o}, 0);
        end
        ext_step();
        if (rst_n) eng_step();
    endtask

    task automatic pulse_wake();
        wake_i = 1'b1;
        tick();
        wake_i = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 40 && loc_busy_o; i++) tick();
    endtask

    initial begin
        seed_dummy = $urandom(32'h5EE9_0A1B);
        // R1: reset state
        for (int i = 0; i < 3; i++) @(negedge clk);
        chk(loc_busy_o && pin_oe_o && !eng_start_o, "R1 reset state",
            {loc_busy_o, pin_oe_o, eng_start_o}, 3'b110);
        rst_n = 1'b1;
        @(negedge clk);
        chk(eng_start_o == 1'b1, "R1 start after reset", eng_start_o, 1);
        chk(loc_busy_o && pin_oe_o, "R1 owns after reset", {loc_busy_o, pin_oe_o}, 3);
        eng_step();
        wait_idle();
        chk(!loc_busy_o && !pin_oe_o, "R2 wait-for-key after config", {loc_busy_o, pin_oe_o}, 0);

        // R9: done while waiting is ignored
        eng_done_i = 1'b1;
        tick();
        tick();
        chk(!loc_busy_o && !pin_oe_o && !eng_pend_o, "R9 done in wait ignored",
            {loc_busy_o, pin_oe_o, eng_pend_o}, 0);

        // R3/R4: wake with outside party idle
        pulse_wake();
        chk(loc_busy_o && eng_pend_o && !pin_oe_o, "R3 request after wake",
            {loc_busy_o, eng_pend_o, pin_oe_o}, 3'b110);
        chk(eng_addr_o == WAKE_A, "R3 wake address", eng_addr_o, WAKE_A);
        tick();
        chk(pin_oe_o && eng_start_o, "R4 grant one edge after request",
            {pin_oe_o, eng_start_o}, 3);

        // R8: wake while owning is ignored
        tick();
        pulse_wake();
        wait_idle();
        for (int i = 0; i < 5; i++) begin
            tick();
            chk(!loc_busy_o && !pin_oe_o, "R8 wake while owning ignored", {loc_busy_o, pin_oe_o}, 0);
        end

        // R10: outside party holds busy
        ext_busy_i = 1'b1;
        for (int i = 0; i < 3; i++) tick();
        pulse_wake();
        for (int i = 0; i < 10; i++) tick();
        chk(!pin_oe_o && loc_busy_o, "R10 request waits", {pin_oe_o, loc_busy_o}, 1);
        eng_done_i = 1'b1;
        tick();
        tick();
        chk(!pin_oe_o && loc_busy_o && eng_pend_o, "R9 done while requesting ignored",
            {pin_oe_o, loc_busy_o, eng_pend_o}, 3'b011);
        ext_busy_i = 1'b0;
        tick();
        chk(!pin_oe_o, "R10 no grant after E", pin_oe_o, 0);
        tick();
        chk(!pin_oe_o, "R10 no grant after E+1", pin_oe_o, 0);
        tick();
        chk(pin_oe_o && eng_start_o, "R10 grant after E+2", {pin_oe_o, eng_start_o}, 3);
        wait_idle();

        // Random phase: outside party active, random wakes
        ext_auto = 1'b1;
        for (int i = 0; i < 4000; i++) begin
            wake_i = ($urandom % 20 == 0);
            tick();
        end
        wake_i = 1'b0;
        ext_auto = 1'b0;
        for (int i = 0; i < 20 && ext_drive; i++) begin
            ext_cnt = 1; ext_st = 2; ext_auto = 1'b1; tick(); ext_auto = 1'b0;
        end
        ext_busy_i = 1'b0;
        for (int i = 0; i < 60; i++) tick();
        chk(!loc_busy_o && !pin_oe_o, "R2 idle after random phase", {loc_busy_o, pin_oe_o}, 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule